// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block sits beside a UART receiver and works out the rate of an unknown serial host. Software arms it with a start request, picks one of two timing windows, and the host then sends an ASCII "A" or "a". The block times a known part of that character on the synchronized receive line. It converts the count into a 16x-oversampling baud divisor and presents the divisor to the receiver's baud generator. While a measurement is pending, the block holds the fractional rate adjustment at zero.

The measurement counter uses a prescaler, so the final count is the divisor with no further arithmetic. In the two-falling-edge window the counter advances once every 32 clocks. In the start-bit window it advances once every 16 clocks. If the counter wraps before the closing edge arrives, a timeout is declared. The block then either stops or, when auto-restart is selected, clears the counter and waits for the next falling edge. Completion and timeout each have a sticky flag with its own enable and write-1-to-clear input. The start/status output is the "pending" indication. It drops by itself when the operation ends.

Top module: `uart_autobaud`

## Requirements
- R1: A one-cycle `start_set_i` (with `start_clr_i` low) makes `active_o` 1 from the next cycle, clears the counter, and latches `mode_i` and `restart_i`. Until the first synchronized falling edge of `rx_i`, the counter stays at zero and nothing is timed. A new `start_set_i` while active re-arms from scratch.
- R2: `start_clr_i` takes priority over `start_set_i` and drops `active_o` at the next edge. An aborted measurement leaves `divisor_o` unchanged and raises neither flag. Later edges on `rx_i` have no effect.
- R3: With mode 0 (`mode_i`=0), `divisor_o` becomes floor(N/32), where N is the number of clocks between the two successive falling edges of `rx_i` (start bit and end of the least significant data bit).
- R4: With mode 1 (`mode_i`=1), `divisor_o` becomes floor(N/16), where N is the number of clocks from the falling edge of `rx_i` to the next rising edge (the start bit).
- R5: On completion, `active_o` falls and `divisor_o` loads in the same cycle. `end_int_o` sets if `end_int_en_i` is 1 at that moment. `divisor_o` never changes while `active_o` is 0.
- R6: If N reaches 2^CNT_W times the prescale (32 in mode 0, 16 in mode 1) without auto-restart, a timeout occurs. `active_o` falls, `divisor_o` is kept, and `to_int_o` sets if `to_int_en_i` is 1.
- R7: With auto-restart latched, a timeout leaves `active_o` at 1 and re-arms on the next falling edge. A later valid character then completes normally.
- R8: Each flag is sticky and is cleared by a one-cycle pulse on its clear input; a setting event in the same cycle wins. A flag whose enable is 0 at the event stays 0.
- R9: `frac_zero_o` is 1 exactly while a measurement is pending (equal to `active_o`).
- R10: `rx_i` passes through a two-stage synchronizer, reset to the idle-high level. A rising edge seen while waiting for the first falling edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line |
| start_set_i | input | 1 | Pulse: begin a measurement |
| start_clr_i | input | 1 | Pulse: abort a measurement |
| mode_i | input | 1 | 0: two falling edges, 1: start-bit length |
| restart_i | input | 1 | Auto-restart after timeout |
| to_int_en_i | input | 1 | Timeout flag enable |
| end_int_en_i | input | 1 | Completion flag enable |
| to_int_clr_i | input | 1 | Write-1-to-clear for the timeout flag |
| end_int_clr_i | input | 1 | Write-1-to-clear for the completion flag |
| active_o | output | 1 | Start/status: 1 while pending |
| frac_zero_o | output | 1 | Forces fractional adjustment to zero |
| divisor_o | output | CNT_W | Measured baud divisor |
| to_int_o | output | 1 | Timeout flag |
| end_int_o | output | 1 | Completion flag |

## Verification
The hardest case to reach from the ports is a counter wrap followed by an automatic re-arm and a good measurement. Reaching it needs the receive line held low for 2^CNT_W prescaled ticks, then released and followed by a clean character without any software action. The bench builds the block with an 8-bit counter, so a wrap costs a few thousand clocks rather than a million. It holds the line low through the wrap and then sends an "A" at a new rate. The same reduced width also makes it cheap to abort mid-character and to re-arm over a line that is already low.

// File: rtl/ab_pkg.sv
package ab_pkg;
  typedef enum logic [1:0] {
    AB_IDLE = 2'd0,
    AB_WAIT = 2'd1,
    AB_MEAS = 2'd2
  } ab_state_t;
endpackage

// File: rtl/ab_rx_sync.sv
module ab_rx_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  logic [SYNC_N-1:0] sh_q;
  logic [SYNC_N-1:0] sh_d;
  logic              prev_q;
  logic              rx_s;

  // R10: synchronizer chain, idle-high reset level
  always_comb begin
    sh_d = {sh_q[SYNC_N-2:0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= rx_s;
    end
  end

  assign rx_s   = sh_q[SYNC_N-1];
  assign fall_o = prev_q & ~rx_s;
  assign rise_o = ~prev_q & rx_s;
endmodule

// File: rtl/ab_meas_cnt.sv
module ab_meas_cnt #(
  parameter int CNT_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             two_bit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             full_o
);
  localparam int PRE_LONG = 2 * OVS;
  localparam int PRE_W    = $clog2(PRE_LONG);

  logic [PRE_W-1:0] pre_q, pre_d, pre_last;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pre_last = two_bit_i ? PRE_W'(PRE_LONG - 1) : PRE_W'(OVS - 1);
    tick_o   = run_i && (pre_q == pre_last);
    pre_d    = pre_q;
    cnt_d    = cnt_q;
    if (clr_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (run_i) begin
      if (tick_o) begin
        pre_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/ab_ctrl.sv
module ab_ctrl
  import ab_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_set_i,
  input  logic             start_clr_i,
  input  logic             mode_i,
  input  logic             restart_i,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             tick_i,
  input  logic             full_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ab_state_t        state_o,
  output logic             cnt_clr_o,
  output logic             cnt_run_o,
  output logic             two_bit_o,
  output logic [CNT_W-1:0] div_o,
  output logic             to_evt_o,
  output logic             end_evt_o
);
  ab_state_t        st_q, st_d;
  logic             mode_q, mode_d;
  logic             rs_q, rs_d;
  logic [CNT_W-1:0] div_q, div_d;
  logic             close_edge;

  always_comb begin
    st_d       = st_q;
    mode_d     = mode_q;
    rs_d       = rs_q;
    div_d      = div_q;
    cnt_clr_o  = 1'b0;
    to_evt_o   = 1'b0;
    end_evt_o  = 1'b0;
    close_edge = mode_q ? rise_i : fall_i;
    if (start_clr_i) begin
      st_d      = AB_IDLE;               // R2 abort wins
      cnt_clr_o = 1'b1;
    end else if (start_set_i) begin
      st_d      = AB_WAIT;               // R1 arm
      mode_d    = mode_i;
      rs_d      = restart_i;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        AB_WAIT: begin
          cnt_clr_o = 1'b1;
          if (fall_i) st_d = AB_MEAS;
        end
        AB_MEAS: begin
          if (tick_i && full_i) begin
            to_evt_o  = 1'b1;            // R6/R7 overflow
            cnt_clr_o = 1'b1;
            st_d      = rs_q ? AB_WAIT : AB_IDLE;
          end else if (close_edge) begin
            end_evt_o = 1'b1;            // R3/R4/R5
            div_d     = cnt_i + CNT_W'(tick_i);
            st_d      = AB_IDLE;
          end
        end
        default: st_d = AB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AB_IDLE;
      mode_q <= 1'b0;
      rs_q   <= 1'b0;
      div_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      rs_q   <= rs_d;
      div_q  <= div_d;
    end
  end

  assign state_o   = st_q;
  assign cnt_run_o = (st_q == AB_MEAS);
  assign two_bit_o = ~mode_q;
  assign div_o     = div_q;
endmodule

// File: rtl/ab_irq.sv
module ab_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  // R8: event with enable sets, clear pulse otherwise clears
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (evt_i[i] && en_i[i])  flag_d[i] = 1'b1;
      else if (clr_i[i])        flag_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud
  import ab_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             start_set_i,
  input  logic             start_clr_i,
  input  logic             mode_i,
  input  logic             restart_i,
  input  logic             to_int_en_i,
  input  logic             end_int_en_i,
  input  logic             to_int_clr_i,
  input  logic             end_int_clr_i,
  output logic             active_o,
  output logic             frac_zero_o,
  output logic [CNT_W-1:0] divisor_o,
  output logic             to_int_o,
  output logic             end_int_o
);
  logic             rx_fall, rx_rise;
  logic             cnt_clr, cnt_run, two_bit, tick, full;
  logic [CNT_W-1:0] cnt_val;
  ab_state_t        st;
  logic             to_evt, end_evt;
  logic [1:0]       flags;

  ab_rx_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .fall_o(rx_fall), .rise_o(rx_rise)
  );

  ab_meas_cnt #(.CNT_W(CNT_W), .OVS(OVS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .run_i(cnt_run),
    .two_bit_i(two_bit), .cnt_o(cnt_val), .tick_o(tick), .full_o(full)
  );

  ab_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_set_i(start_set_i), .start_clr_i(start_clr_i),
    .mode_i(mode_i), .restart_i(restart_i),
    .fall_i(rx_fall), .rise_i(rx_rise), .tick_i(tick), .full_i(full),
    .cnt_i(cnt_val), .state_o(st), .cnt_clr_o(cnt_clr), .cnt_run_o(cnt_run),
    .two_bit_o(two_bit), .div_o(divisor_o),
    .to_evt_o(to_evt), .end_evt_o(end_evt)
  );

  ab_irq #(.N(2)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .evt_i({end_evt, to_evt}),
    .en_i({end_int_en_i, to_int_en_i}),
    .clr_i({end_int_clr_i, to_int_clr_i}),
    .flag_o(flags)
  );

  assign active_o    = (st != AB_IDLE);
  assign frac_zero_o = active_o;           // R9
  assign to_int_o    = flags[0];
  assign end_int_o   = flags[1];
endmodule

// File: rtl/ab_checker.sv
module ab_checker
  import ab_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_set_i,
  input logic             start_clr_i,
  input logic             end_int_clr_i,
  input logic             to_int_clr_i,
  input logic             active_o,
  input logic             frac_zero_o,
  input logic [CNT_W-1:0] divisor_o,
  input logic             to_int_o,
  input logic             end_int_o,
  input ab_state_t        st,
  input logic [CNT_W-1:0] cnt_val
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_set_i && !start_clr_i) |=> active_o);

  assert_cnt_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == AB_WAIT) |-> (cnt_val == '0));

  assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr_i |=> !active_o);

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> $stable(divisor_o));

  assert_end_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_int_o) |-> $fell(active_o));

  assert_to_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_int_o) |-> $past(active_o));

  assert_end_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_int_clr_i && !active_o) |=> !end_int_o);

  assert_to_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (to_int_clr_i && !active_o) |=> !to_int_o);

  assert_frac_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> !frac_zero_o);
endmodule

bind uart_autobaud ab_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_set_i(start_set_i), .start_clr_i(start_clr_i),
  .end_int_clr_i(end_int_clr_i), .to_int_clr_i(to_int_clr_i),
  .active_o(active_o), .frac_zero_o(frac_zero_o), .divisor_o(divisor_o),
  .to_int_o(to_int_o), .end_int_o(end_int_o), .st(st), .cnt_val(cnt_val)
);

// File: tb/uart_autobaud_tb.sv
module uart_autobaud_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_i = 1'b1;
  logic start_set_i = 0, start_clr_i = 0, mode_i = 0, restart_i = 0;
  logic to_int_en_i = 0, end_int_en_i = 0, to_int_clr_i = 0, end_int_clr_i = 0;
  logic active_o, frac_zero_o, to_int_o, end_int_o;
  logic [W-1:0] divisor_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_autobaud #(.CNT_W(W)) u_dut (.*);

  // behavioural reference model
  int m_s1, m_s2, m_prev, m_st, m_mode, m_rs, m_div, m_to, m_end;
  longint m_t, m_t0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_st = 0; m_mode = 0; m_rs = 0;
      m_div = 0; m_to = 0; m_end = 0; m_t = 0; m_t0 = 0;
    end else begin
      int fall, rise, to_e, end_e, p;
      longint n;
      fall = (m_prev == 1 && m_s2 == 0);
      rise = (m_prev == 0 && m_s2 == 1);
      to_e = 0; end_e = 0;
      if (start_clr_i) m_st = 0;
      else if (start_set_i) begin m_st = 1; m_mode = mode_i; m_rs = restart_i; end
      else if (m_st == 1) begin
        if (fall) begin m_st = 2; m_t0 = m_t; end
      end else if (m_st == 2) begin
        n = m_t - m_t0;
        p = m_mode ? 16 : 32;
        if (n == longint'(p) * (longint'(1) << W)) begin
          to_e = 1; m_st = m_rs ? 1 : 0;
        end else if (m_mode ? rise : fall) begin
          m_div = int'(n / p); end_e = 1; m_st = 0;
        end
      end
      if (to_e && to_int_en_i) m_to = 1; else if (to_int_clr_i) m_to = 0;
      if (end_e && end_int_en_i) m_end = 1; else if (end_int_clr_i) m_end = 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(rx_i);
      m_t++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check(cur_req, "active", int'(active_o), (m_st != 0) ? 1 : 0);
      check("R9", "frac_zero", int'(frac_zero_o), (m_st != 0) ? 1 : 0);
      check(cur_req, "divisor", int'(divisor_o), m_div & ((1 << W) - 1));
      check(cur_req, "to_int", int'(to_int_o), m_to);
      check(cur_req, "end_int", int'(end_int_o), m_end);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(int md, int rs);
    @(negedge clk); start_set_i = 1; mode_i = md[0]; restart_i = rs[0];
    @(negedge clk); start_set_i = 0;
  endtask

  task automatic send_char(logic [7:0] c, int bit_len);
    @(negedge clk);
    rx_i = 1'b0; cyc(bit_len);
    for (int i = 0; i < 8; i++) begin rx_i = c[i]; cyc(bit_len); end
    rx_i = 1'b1; cyc(bit_len + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    check("R1", "reset active", int'(active_o), 0);
    check("R10", "reset divisor", int'(divisor_o), 0);
    check("R8", "reset flags", int'(to_int_o | end_int_o), 0);

    // mode 0, divisor 5, completion flag enabled
    cur_req = "R3"; end_int_en_i = 1;
    arm(0, 0);
    check("R1", "armed", int'(active_o), 1);
    send_char(8'h41, 80);
    check("R3", "mode0 divisor", int'(divisor_o), 5);
    check("R5", "end flag", int'(end_int_o), 1);
    check("R5", "active dropped", int'(active_o), 0);
    cur_req = "R8";
    @(negedge clk); end_int_clr_i = 1; @(negedge clk); end_int_clr_i = 0; cyc(1);
    check("R8", "end flag cleared", int'(end_int_o), 0);

    // mode 1, divisor 7, completion flag disabled
    cur_req = "R4"; end_int_en_i = 0;
    arm(1, 0);
    send_char(8'h61, 115);
    check("R4", "mode1 divisor", int'(divisor_o), 7);
    check("R8", "disabled end flag", int'(end_int_o), 0);

    // rising edge while waiting is ignored
    cur_req = "R10";
    @(negedge clk); rx_i = 0; cyc(6);
    arm(1, 0); cyc(10);
    rx_i = 1; cyc(20);
    check("R10", "still waiting", int'(active_o), 1);
    check("R10", "divisor kept", int'(divisor_o), 7);
    send_char(8'h41, 96);
    check("R10", "divisor after ignored rise", int'(divisor_o), 6);

    // abort mid-measurement
    cur_req = "R2"; end_int_en_i = 1; to_int_en_i = 1;
    arm(0, 0);
    @(negedge clk); rx_i = 0; cyc(100);
    @(negedge clk); start_clr_i = 1; start_set_i = 1; @(negedge clk); start_clr_i = 0; start_set_i = 0;
    check("R2", "aborted", int'(active_o), 0);
    rx_i = 1; cyc(40); rx_i = 0; cyc(40); rx_i = 1; cyc(40);
    check("R2", "divisor untouched", int'(divisor_o), 6);
    check("R2", "no flags", int'(to_int_o | end_int_o), 0);

    // timeout without restart, mode 1
    cur_req = "R6";
    arm(1, 0);
    @(negedge clk); rx_i = 0; cyc(16 * (1 << W) + 20);
    check("R6", "stopped on timeout", int'(active_o), 0);
    check("R6", "timeout flag", int'(to_int_o), 1);
    check("R6", "divisor kept", int'(divisor_o), 6);
    rx_i = 1; cyc(10);
    @(negedge clk); to_int_clr_i = 1; @(negedge clk); to_int_clr_i = 0; cyc(1);
    check("R8", "timeout flag cleared", int'(to_int_o), 0);

    // timeout with auto-restart, mode 0, then good character
    cur_req = "R7";
    arm(0, 1);
    @(negedge clk); rx_i = 0; cyc(32 * (1 << W) + 20);
    check("R7", "still active after wrap", int'(active_o), 1);
    check("R7", "timeout flag", int'(to_int_o), 1);
    rx_i = 1; cyc(30);
    send_char(8'h41, 48);
    check("R7", "divisor after restart", int'(divisor_o), 3);
    check("R5", "end flag after restart", int'(end_int_o), 1);

    // re-arm while active over a low line
    cur_req = "R1";
    arm(1, 0);
    @(negedge clk); rx_i = 0; cyc(50);
    arm(1, 0);
    cyc(30);
    check("R1", "re-armed", int'(active_o), 1);
    rx_i = 1; cyc(20);
    send_char(8'h41, 64);
    check("R1", "divisor after re-arm", int'(divisor_o), 4);

    cyc(5);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule